// File: doc/BRIEF.md
# BCD Clock-Calendar with Fractional Prescaler

This block keeps time of day and calendar date in BCD. A one-cycle strobe arriving at 4096 Hz enters a two-state fractional divider, which emits a 100 Hz strobe. The divider alternates between a long phase, dividing by 41, and a short phase, dividing by 40. On each 100 Hz strobe a single-cycle carry chain advances eight byte-wide fields: hundredths, seconds, minutes, hours, day-of-week, date, month and year. The chain corrects month lengths, inserts leap days and supports both a 24-hour and a 12-hour hour encoding.

Software loads any subset of the fields through a 64-bit write port with one enable per byte. A write restarts the divider phase. A capture strobe copies all eight fields into a holding register, and the read bus returns only that copy, so a multi-byte read stays coherent while counting goes on. Two single-cycle pulses mark a seconds advance and a midnight rollover.

The divider phase machine has two states. `PH_LONG` counts 41 input strobes per output strobe, and `LONG_TO_SHORT` is taken after the 24th such period. `PH_SHORT` counts 40 input strobes, and `SHORT_TO_LONG` is taken after one period. A write forces `RESTART`, which returns the machine to `PH_LONG` with its counts cleared.

Top module: `bcd_clock_cal`

## Requirements
- R1: Starting from a restart, output strobes 1 to 24 each come 41 input strobes after the one before. Strobe 25 comes 40 input strobes later. So 25 output strobes consume exactly 1024 input strobes, and the sequence then repeats.
- R2: After reset, the captured fields read year 00, month 01, date 01, day-of-week 01, hours 00 (24-hour mode) and 00:00.00 for minutes, seconds and hundredths. Byte i of the bus holds field i in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year.
- R3: Hundredths, seconds and minutes count in BCD. Hundredths wrap 99 to 00, and seconds and minutes wrap 59 to 00. Every hundredths wrap gives a one-cycle `sec_pulse`.
- R4: In 24-hour mode (hours bit 6 = 0), bit 5 is the tens-of-hours bit for 20 to 23. Hour 23 wraps to 00, and that step raises `midnight_pulse` together with `sec_pulse`.
- R5: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, hour 1 to 12 in bits 4:0), hour 11 goes to 12 and toggles PM. Hour 12 goes to 1 and keeps PM. The step from 11 PM to 12 AM is midnight.
- R6: At midnight the date goes to 01 and the month advances once the date has reached the last day of the month. That last day is 30 for April, June, September and November and 31 for the other months except February.
- R7: February ends on 29 when the BCD year is divisible by four, and on 28 otherwise.
- R8: Day-of-week advances at midnight and wraps from 7 to 1.
- R9: Month 12 wraps to 01 at its last day, and the year advances at that step, wrapping 99 to 00.
- R10: A write changes only the bytes whose enable is set. A write with at least one enable set cancels any step that falls on the same cycle.
- R11: A write with any enable set restarts the divider. The next 100 Hz strobe then follows the 41st input strobe after the write.
- R12: `snap_data` changes only in the cycle after `snap_req` and holds its value while the time advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4k | input | 1 | One-cycle strobe at 4096 Hz |
| wr_en | input | 1 | Field write strobe |
| wr_be | input | 8 | Per-field byte enables |
| wr_data | input | 64 | Write data, byte i feeds field i |
| snap_req | input | 1 | Capture all fields into the read register |
| snap_data | output | 64 | Captured fields, byte i is field i |
| tick_100 | output | 1 | 100 Hz strobe from the fractional divider |
| sec_pulse | output | 1 | One cycle when the seconds field advances |
| midnight_pulse | output | 1 | One cycle when the day rolls over |

## Verification
The carry chain is driven from starting times chosen so that a single 100 Hz step reaches a different depth of the chain each time. One step only bumps hundredths, another ripples into seconds or minutes, and others cross midnight in each hour encoding. Other starting times cross the ends of 30-day and 31-day months, February in leap and non-leap years, and the year wrap. Comparing these results shows whether each wrap point and each month-length choice is made independently. A full 1024-strobe run after a restart checks that the 24 long periods come before the single short one. Partial writes, a restart in the middle of a period and capture-while-counting check the write and read paths.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int NFIELD  = 8;
    localparam int F_HS    = 0;
    localparam int F_SEC   = 1;
    localparam int F_MIN   = 2;
    localparam int F_HR    = 3;
    localparam int F_DOW   = 4;
    localparam int F_DATE  = 5;
    localparam int F_MON   = 6;
    localparam int F_YR    = 7;

    typedef enum logic [0:0] {
        PH_LONG  = 1'b0,
        PH_SHORT = 1'b1
    } phase_e;

    typedef logic [NFIELD-1:0][7:0] fields_t;

    // Increment a two-digit BCD value (no wrap handling beyond digits).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // BCD year divisible by four.
    function automatic logic is_leap(input logic [7:0] yr);
        logic ev;
        ev = ~yr[4];
        return (ev  && (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8)) ||
               (!ev && (yr[3:0] == 4'd2 || yr[3:0] == 4'd6));
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        logic [7:0] r;
        case (mo)
            8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    // Returns {day_carry, next_hours_byte}.
    function automatic logic [8:0] hour_advance(input logic [7:0] h);
        logic [8:0] r;
        logic [7:0] inc;
        if (h[6]) begin
            inc = bcd_inc({3'b000, h[4:0]});
            if (h[4:0] == 5'h11)      r = {h[5], 1'b0, 1'b1, ~h[5], 5'h12};
            else if (h[4:0] == 5'h12) r = {1'b0, 1'b0, 1'b1, h[5], 5'h01};
            else                      r = {1'b0, 1'b0, 1'b1, h[5], inc[4:0]};
        end else begin
            inc = bcd_inc({2'b00, h[5:0]});
            if (h[5:0] == 6'h23)      r = {1'b1, 8'h00};
            else                      r = {1'b0, 2'b00, inc[5:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
module bcdcal_prescaler
    import bcdcal_pkg::*;
#(
    parameter int LONG_DIV  = 41,
    parameter int SHORT_DIV = 40,
    parameter int LONG_RUNS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic restart,
    output logic tick_out
);
    localparam int CNT_W = $clog2(LONG_DIV);
    localparam int RUN_W = $clog2(LONG_RUNS + 1);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_DIV - 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_DIV - 1);
    localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(LONG_RUNS - 1);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             term;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        run_d   = run_q;
        term    = 1'b0;
        unique case (state_q)
            PH_LONG: begin
                if (tick_in) begin
                    if (cnt_q == LONG_LIM) begin
                        term  = 1'b1;
                        cnt_d = '0;
                        if (run_q == RUN_LAST) begin
                            run_d   = '0;
                            state_d = PH_SHORT;   // LONG_TO_SHORT
                        end else begin
                            run_d = run_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_SHORT: begin
                if (tick_in) begin
                    if (cnt_q == SHORT_LIM) begin
                        term    = 1'b1;
                        cnt_d   = '0;
                        state_d = PH_LONG;        // SHORT_TO_LONG
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
        if (restart) begin                        // RESTART
            state_d = PH_LONG;
            cnt_d   = '0;
            run_d   = '0;
            term    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LONG;
            cnt_q   <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            run_q   <= run_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= term;
    end

endmodule

// File: rtl/bcdcal_counter.sv
module bcdcal_counter
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_hit,
    input  logic [NFIELD-1:0] wr_be,
    input  fields_t           wr_fields,
    output fields_t           live,
    output logic              sec_pulse,
    output logic              midnight_pulse
);
    localparam logic [7:0] DOW_LAST = 8'h07;

    fields_t fld, nxt;
    logic    sec_c, day_c;

    always_comb begin
        nxt   = fld;
        sec_c = 1'b0;
        day_c = 1'b0;
        if (fld[F_HS] == 8'h99) begin
            nxt[F_HS] = 8'h00;
            sec_c     = 1'b1;
            if (fld[F_SEC] == 8'h59) begin
                nxt[F_SEC] = 8'h00;
                if (fld[F_MIN] == 8'h59) begin
                    nxt[F_MIN] = 8'h00;
                    {day_c, nxt[F_HR]} = hour_advance(fld[F_HR]);
                    if (day_c) begin
                        nxt[F_DOW] = (fld[F_DOW] == DOW_LAST) ? 8'h01 : bcd_inc(fld[F_DOW]);
                        if (fld[F_DATE] == month_last(fld[F_MON], fld[F_YR])) begin
                            nxt[F_DATE] = 8'h01;
                            if (fld[F_MON] == 8'h12) begin
                                nxt[F_MON] = 8'h01;
                                nxt[F_YR]  = (fld[F_YR] == 8'h99) ? 8'h00 : bcd_inc(fld[F_YR]);
                            end else begin
                                nxt[F_MON] = bcd_inc(fld[F_MON]);
                            end
                        end else begin
                            nxt[F_DATE] = bcd_inc(fld[F_DATE]);
                        end
                    end
                end else begin
                    nxt[F_MIN] = bcd_inc(fld[F_MIN]);
                end
            end else begin
                nxt[F_SEC] = bcd_inc(fld[F_SEC]);
            end
        end else begin
            nxt[F_HS] = bcd_inc(fld[F_HS]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld            <= '0;
            fld[F_DOW]     <= 8'h01;
            fld[F_DATE]    <= 8'h01;
            fld[F_MON]     <= 8'h01;
            sec_pulse      <= 1'b0;
            midnight_pulse <= 1'b0;
        end else if (wr_hit) begin
            for (int i = 0; i < NFIELD; i++) begin
                if (wr_be[i]) fld[i] <= wr_fields[i];
            end
            sec_pulse      <= 1'b0;
            midnight_pulse <= 1'b0;
        end else if (step) begin
            fld            <= nxt;
            sec_pulse      <= sec_c;
            midnight_pulse <= day_c;
        end else begin
            sec_pulse      <= 1'b0;
            midnight_pulse <= 1'b0;
        end
    end

    assign live = fld;

endmodule

// File: rtl/bcdcal_snapshot.sv
module bcdcal_snapshot
    import bcdcal_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    capture,
    input  fields_t live,
    output fields_t held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held         <= '0;
            held[F_DOW]  <= 8'h01;
            held[F_DATE] <= 8'h01;
            held[F_MON]  <= 8'h01;
        end else if (capture) begin
            held <= live;
        end
    end
endmodule

// File: rtl/bcd_clock_cal.sv
module bcd_clock_cal
    import bcdcal_pkg::*;
#(
    parameter int LONG_DIV  = 41,
    parameter int SHORT_DIV = 40,
    parameter int LONG_RUNS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_4k,
    input  logic        wr_en,
    input  logic [7:0]  wr_be,
    input  logic [63:0] wr_data,
    input  logic        snap_req,
    output logic [63:0] snap_data,
    output logic        tick_100,
    output logic        sec_pulse,
    output logic        midnight_pulse
);
    logic    wr_hit;
    fields_t live, held;

    assign wr_hit = wr_en && (|wr_be);

    bcdcal_prescaler #(
        .LONG_DIV (LONG_DIV),
        .SHORT_DIV(SHORT_DIV),
        .LONG_RUNS(LONG_RUNS)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_4k),
        .restart (wr_hit),
        .tick_out(tick_100)
    );

    bcdcal_counter u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (tick_100),
        .wr_hit        (wr_hit),
        .wr_be         (wr_be),
        .wr_fields     (fields_t'(wr_data)),
        .live          (live),
        .sec_pulse     (sec_pulse),
        .midnight_pulse(midnight_pulse)
    );

    bcdcal_snapshot u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(snap_req),
        .live   (live),
        .held   (held)
    );

    assign snap_data = 64'(held);

endmodule

// File: rtl/bcd_clock_cal_chk.sv
module bcd_clock_cal_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_4k,
    input logic        wr_en,
    input logic [7:0]  wr_be,
    input logic        snap_req,
    input logic [63:0] snap_data,
    input logic        tick_100,
    input logic        sec_pulse,
    input logic        midnight_pulse
);
    p_tick_from_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_100 |-> $past(tick_4k));

    p_sec_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(tick_100));

    p_hs_digits_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_data[3:0] <= 4'd9) && (snap_data[7:4] <= 4'd9));

    p_midnight_with_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        midnight_pulse |-> sec_pulse);

    p_dow_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_data[39:32] >= 8'h01) && (snap_data[39:32] <= 8'h07));

    p_write_cancels_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_be)) |=> !tick_100);

    p_snap_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_data));
endmodule

bind bcd_clock_cal bcd_clock_cal_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_4k       (tick_4k),
    .wr_en         (wr_en),
    .wr_be         (wr_be),
    .snap_req      (snap_req),
    .snap_data     (snap_data),
    .tick_100      (tick_100),
    .sec_pulse     (sec_pulse),
    .midnight_pulse(midnight_pulse)
);

// File: tb/bcd_clock_cal_bench.sv
`timescale 1ns/1ps
module bcd_clock_cal_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_4k = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic        snap_req = 1'b0;
    logic [63:0] snap_data;
    logic        tick_100, sec_pulse, midnight_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int in_cnt = 0;
    int tick_seen = 0;
    int sec_seen = 0;
    int mid_seen = 0;
    int tick_at [32];
    int done = 0;

    always #2.5 clk = ~clk;

    bcd_clock_cal u_bcd_clock_cal (
        .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .snap_req(snap_req), .snap_data(snap_data),
        .tick_100(tick_100), .sec_pulse(sec_pulse), .midnight_pulse(midnight_pulse)
    );

    // {start, expected after one hundredths step, sec_pulse, midnight_pulse}
    // byte order within 64 bits: yr mo da dw hr mi se hs
    localparam int NVEC = 16;
    localparam logic [129:0] VEC [NVEC] = '{
        {64'h00_01_01_01_00_00_00_05, 64'h00_01_01_01_00_00_00_06, 1'b0, 1'b0},
        {64'h00_01_01_01_00_00_12_99, 64'h00_01_01_01_00_00_13_00, 1'b1, 1'b0},
        {64'h00_01_01_01_00_00_59_99, 64'h00_01_01_01_00_01_00_00, 1'b1, 1'b0},
        {64'h24_06_15_03_23_59_59_99, 64'h24_06_16_04_00_00_00_00, 1'b1, 1'b1},
        {64'h24_06_15_03_19_59_59_99, 64'h24_06_15_03_20_00_00_00, 1'b1, 1'b0},
        {64'h24_06_15_03_51_59_59_99, 64'h24_06_15_03_72_00_00_00, 1'b1, 1'b0},
        {64'h24_06_15_03_72_59_59_99, 64'h24_06_15_03_61_00_00_00, 1'b1, 1'b0},
        {64'h24_06_15_03_71_59_59_99, 64'h24_06_16_04_52_00_00_00, 1'b1, 1'b1},
        {64'h24_04_30_02_23_59_59_99, 64'h24_05_01_03_00_00_00_00, 1'b1, 1'b1},
        {64'h24_01_30_02_23_59_59_99, 64'h24_01_31_03_00_00_00_00, 1'b1, 1'b1},
        {64'h24_02_28_02_23_59_59_99, 64'h24_02_29_03_00_00_00_00, 1'b1, 1'b1},
        {64'h23_02_28_02_23_59_59_99, 64'h23_03_01_03_00_00_00_00, 1'b1, 1'b1},
        {64'h00_02_29_02_23_59_59_99, 64'h00_03_01_03_00_00_00_00, 1'b1, 1'b1},
        {64'h24_06_15_07_23_59_59_99, 64'h24_06_16_01_00_00_00_00, 1'b1, 1'b1},
        {64'h99_12_31_05_23_59_59_99, 64'h00_01_01_06_00_00_00_00, 1'b1, 1'b1},
        {64'h24_08_31_05_23_59_59_99, 64'h24_09_01_06_00_00_00_00, 1'b1, 1'b1}
    };
    string VTAG [NVEC] = '{"R3", "R3", "R3", "R4", "R4", "R5", "R5", "R5",
                           "R6", "R6", "R7", "R7", "R7", "R8", "R9", "R6"};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor of single-cycle outputs, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick_100) begin
                if (tick_seen < 32) tick_at[tick_seen] = in_cnt;
                tick_seen++;
            end
            if (sec_pulse) sec_seen++;
            if (midnight_pulse) mid_seen++;
        end
    end

    task automatic pulse_tick();
        @(negedge clk); tick_4k = 1'b1; in_cnt++;
        @(negedge clk); tick_4k = 1'b0;
    endtask

    task automatic write_fields(input logic [7:0] be, input logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_be = '0;
        tick_seen = 0; sec_seen = 0; mid_seen = 0; in_cnt = 0;
    endtask

    task automatic take_snap();
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset contents
        take_snap();
        check("R2 reset fields", snap_data, 64'h00_01_01_01_00_00_00_00);
        check("R2 no tick after reset", {63'd0, tick_100}, 64'd0);

        // table walk: one hundredths step from each starting time
        for (int i = 0; i < NVEC; i++) begin
            write_fields(8'hFF, VEC[i][129:66]);
            repeat (41) pulse_tick();
            repeat (3) @(negedge clk);
            take_snap();
            check({VTAG[i], " fields"}, snap_data, VEC[i][65:2]);
            check({VTAG[i], " sec_pulse count"}, 64'(sec_seen), 64'(VEC[i][1]));
            check({VTAG[i], " midnight_pulse count"}, 64'(mid_seen), 64'(VEC[i][0]));
        end

        // R1: 24 periods of 41 then one of 40 across 1024 input strobes
        write_fields(8'hFF, 64'h00_01_01_01_00_00_00_00);
        repeat (1024) pulse_tick();
        repeat (3) @(negedge clk);
        check("R1 strobes in 1024 inputs", 64'(tick_seen), 64'd25);
        for (int k = 0; k < 24; k++)
            check("R1 long period end", 64'(tick_at[k]), 64'(41 * (k + 1)));
        check("R1 short period end", 64'(tick_at[24]), 64'd1024);
        take_snap();
        check("R1 25 hundredths counted", snap_data, 64'h00_01_01_01_00_00_00_25);

        // R10: partial write touches only the enabled byte
        base = 64'h24_06_15_03_10_20_30_40;
        write_fields(8'hFF, base);
        write_fields(8'h04, 64'h33_33_33_33_33_42_33_33);
        take_snap();
        check("R10 only minutes written", snap_data, 64'h24_06_15_03_10_42_30_40);
        write_fields(8'h00, 64'h11_11_11_11_11_11_11_11);
        take_snap();
        check("R10 zero enables ignored", snap_data, 64'h24_06_15_03_10_42_30_40);

        // R11: restart in mid-period pushes the next step a full period out
        write_fields(8'hFF, base);
        repeat (20) pulse_tick();
        write_fields(8'h01, 64'h00_00_00_00_00_00_00_50);
        repeat (40) pulse_tick();
        repeat (3) @(negedge clk);
        check("R11 no step within 40 inputs", 64'(tick_seen), 64'd0);
        pulse_tick();
        repeat (3) @(negedge clk);
        check("R11 step at 41st input", 64'(tick_seen), 64'd1);
        take_snap();
        check("R11 hundredths advanced once", snap_data, 64'h24_06_15_03_10_20_30_51);

        // R12: capture holds while the time keeps running
        write_fields(8'hFF, 64'h24_06_15_03_10_20_30_10);
        take_snap();
        check("R12 capture", snap_data, 64'h24_06_15_03_10_20_30_10);
        repeat (82) pulse_tick();
        repeat (3) @(negedge clk);
        check("R12 capture held", snap_data, 64'h24_06_15_03_10_20_30_10);
        take_snap();
        check("R12 new capture", snap_data, 64'h24_06_15_03_10_20_30_12);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule